// File: doc/BRIEF.md
# Instruction-Side Exception Detector

This block sits beside the decode stage of a 32-bit RISC pipeline. Each cycle in which the fetch stage presents a valid instruction, it looks at three things. The first is the fetch response, on whichever of three fetch paths delivered the word. The second is the major opcode of the word. The third is the current privilege level. From these it decides whether the instruction must trap with an instruction bus error, an illegal opcode or a privileged instruction exception.

The decision is registered. It appears as a one-hot request vector one clock later, and it lasts for one cycle.

In fault-tolerant mode, a bus error or illegal opcode can arrive while an exception handler is already running with exceptions disabled. Such a second fault does not raise a request. It sets a sticky halt/error output instead, and that output stays set until reset. Fetch-path errors are filtered by cache and ECC conditions, so that responses which the cache or the ECC logic already absorbs do not trap.

Top module: `ifetch_exc_detect`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after reset, `exc_req` is 3'b000 and `halt_err` is 0, whatever the other inputs are.
- R2: Legality depends only on the major opcode `instr_word[31:26]`. Bits 25..0 are ignored, except for the all-zero word of R4. Opcodes 0x00 to 0x2F are legal. Opcodes 0x38 to 0x3F are illegal and raise `exc_req[1]`.
- R3: Opcodes 0x30 to 0x37 are optional. Opcode N in this range is legal only when `opt_enable[N]` is 1. Otherwise it raises `exc_req[1]`.
- R4: With `ZERO_ILLEGAL` at 1 (the default), the word 0x00000000 raises `exc_req[1]`. Other words with opcode 0x00 are legal.
- R5: On the peripheral path (`fetch_path`=0), `fetch_err`=1 raises `exc_req[0]`. The ECC inputs have no effect on this path.
- R6: On the cache path (`fetch_path`=1), `fetch_err`=1 raises `exc_req[0]` only when `cache_inhibit`=1, or when `cache_enabled`=0 with `ALWAYS_CACHE`=1 (the default). In every other case the response is ignored.
- R7: On the local-memory path (`fetch_path`=2), `ecc_uncorr`=1 raises `exc_req[0]`. `ecc_corr` raises it only when `CE_TRAP`=1, and the default is 0. `fetch_err` is ignored on this path. Path 3 never raises a bus error.
- R8: Opcodes 0x2C and 0x2D are privileged. With `user_mode`=1 they raise `exc_req[2]`. With `user_mode`=0 they raise nothing.
- R9: At most one bit of `exc_req` is set. Priority order is bus error (bit 0), then illegal opcode (bit 1), then privileged (bit 2).
- R10: A request appears on the clock edge that samples `in_valid`=1, and it lasts exactly one cycle. A cycle with `in_valid`=0 never produces a request.
- R11: With `FAULT_TOL`=1 (the default), a valid bus or illegal-opcode fault seen while `exc_in_progress`=1 and `exc_enable`=0 sets `halt_err` on that edge and raises no request. A privileged fault in that state traps as usual. `halt_err` stays 1 until reset.
- R12: While `halt_err` is 1, `exc_req` stays 3'b000 for every input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A decoded instruction is present this cycle |
| instr_word | input | 32 | Instruction word; major opcode in bits 31..26 |
| fetch_path | input | 2 | Path of the fetch: 0 peripheral, 1 cache, 2 local memory, 3 none |
| fetch_err | input | 1 | Error response from the peripheral or cache port |
| ecc_uncorr | input | 1 | Uncorrectable ECC error from local memory |
| ecc_corr | input | 1 | Correctable ECC error from local memory |
| cache_enabled | input | 1 | Instruction cache is turned on |
| cache_inhibit | input | 1 | Access is marked cache-inhibited |
| user_mode | input | 1 | Processor is in user mode |
| opt_enable | input | 64 | Per-opcode enable for optional instructions |
| exc_in_progress | input | 1 | An exception handler is running |
| exc_enable | input | 1 | Exceptions are enabled |
| exc_req | output | 3 | One-hot request: bit0 bus, bit1 illegal, bit2 privileged |
| halt_err | output | 1 | Sticky pipeline halt and external error |

## Verification
Every result is due exactly one rising edge after the cycle in which the stimulus is presented. The bus, illegal and privileged requests appear on that edge, and so does the setting of `halt_err`. A request clears again on the following edge.

The bench changes inputs on the falling edge and waits one rising edge. It compares outputs on the next falling edge against a model evaluated on the inputs it just drove. Idle cycles placed after faults confirm the one-cycle width of a request and the stickiness of the halt.

// File: rtl/ifx_pkg.sv
// Shared types for the instruction-side exception detector.
// Assumes a 2-bit fetch path code and a 3-bit one-hot request vector.
package ifx_pkg;
    typedef enum logic [1:0] {
        PATH_PERIPH = 2'd0,
        PATH_CACHE  = 2'd1,
        PATH_LOCAL  = 2'd2,
        PATH_NONE   = 2'd3
    } fetch_path_e;

    localparam int EXC_W    = 3;
    localparam int EXC_BUS  = 0;
    localparam int EXC_ILL  = 1;
    localparam int EXC_PRIV = 2;

    typedef logic [EXC_W-1:0] exc_vec_t;
endpackage

// File: rtl/ifx_opcode_chk.sv
// Major-opcode legality and privilege decode (combinational).
// Assumes the major opcode occupies the top OPC_W bits of the word.
// A per-opcode legality vector is built from the base and optional masks.
module ifx_opcode_chk #(
    parameter int                      INSTR_W      = 32,
    parameter int                      OPC_W        = 6,
    parameter logic [(2**OPC_W)-1:0]   BASE_LEGAL   = '0,
    parameter logic [(2**OPC_W)-1:0]   OPT_MASK     = '0,
    parameter logic [(2**OPC_W)-1:0]   PRIV_MASK    = '0,
    parameter bit                      ZERO_ILLEGAL = 1'b1
) (
    input  logic [INSTR_W-1:0]         instr,
    input  logic [(2**OPC_W)-1:0]      opt_en,
    output logic                       illegal,
    output logic                       priv_hit
);
    localparam int NUM_OPC = 2**OPC_W;

    logic [NUM_OPC-1:0] legal_vec;
    logic [OPC_W-1:0]   opc;
    logic               zero_word;

    assign opc = instr[INSTR_W-1 -: OPC_W];

    // One legality bit per opcode: base set, or an optional opcode that is enabled
    for (genvar g = 0; g < NUM_OPC; g++) begin : g_legal
        assign legal_vec[g] = BASE_LEGAL[g] | (OPT_MASK[g] & opt_en[g]);
    end

    // Recognize the all-zero word when that check is configured
    always_comb begin
        zero_word = ZERO_ILLEGAL && (instr == '0);
    end

    // Final illegal and privileged flags for the current opcode
    always_comb begin
        illegal  = !legal_vec[opc] || zero_word;
        priv_hit = PRIV_MASK[opc];
    end
endmodule

// File: rtl/ifx_bus_filter.sv
// Decides whether a fetch response is an instruction bus exception.
// Assumes one fetch path code per instruction. Error inputs that do not
// belong to the selected path are ignored.
module ifx_bus_filter
    import ifx_pkg::*;
#(
    parameter bit ALWAYS_CACHE = 1'b1,
    parameter bit CE_TRAP      = 1'b0
) (
    input  logic [1:0] path,
    input  logic       fetch_err,
    input  logic       ecc_ue,
    input  logic       ecc_ce,
    input  logic       cache_on,
    input  logic       cache_inh,
    output logic       bus_exc
);
    fetch_path_e path_e;
    logic        cache_bypassed;

    assign path_e = fetch_path_e'(path);

    // The cache port reports errors only when the cache is not serving the access
    always_comb begin
        cache_bypassed = cache_inh || (ALWAYS_CACHE && !cache_on);
    end

    // Select the error condition that applies to the active path
    always_comb begin
        case (path_e)
            PATH_PERIPH: bus_exc = fetch_err;
            PATH_CACHE:  bus_exc = fetch_err && cache_bypassed;
            PATH_LOCAL:  bus_exc = ecc_ue || (CE_TRAP && ecc_ce);
            default:     bus_exc = 1'b0;
        endcase
    end
endmodule

// File: rtl/ifx_req_reg.sv
// Prioritizes the raw faults, registers the one-hot request and keeps the
// fault-tolerant halt latch. Assumes the caller supplies decoded faults for
// the instruction in the same cycle as valid.
module ifx_req_reg
    import ifx_pkg::*;
#(
    parameter bit FAULT_TOL = 1'b1
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     valid,
    input  logic     bus_exc,
    input  logic     illegal,
    input  logic     priv_hit,
    input  logic     user_mode,
    input  logic     in_prog,
    input  logic     exc_en,
    output exc_vec_t exc_req,
    output logic     halt
);
    exc_vec_t nxt_req;
    exc_vec_t req_q;
    logic     halt_q;
    logic     freeze;

    // Priority encode: bus error, then illegal opcode, then privileged
    always_comb begin
        nxt_req = '0;
        if (bus_exc)
            nxt_req[EXC_BUS] = 1'b1;
        else if (illegal)
            nxt_req[EXC_ILL] = 1'b1;
        else if (priv_hit && user_mode)
            nxt_req[EXC_PRIV] = 1'b1;
    end

    // A second hard fault inside a handler with exceptions off halts the pipeline
    always_comb begin
        freeze = FAULT_TOL && valid && !halt_q && in_prog && !exc_en
                 && (bus_exc || illegal);
    end

    // Register the request for one cycle and hold the sticky halt
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q  <= '0;
            halt_q <= 1'b0;
        end else begin
            halt_q <= halt_q | freeze;
            req_q  <= (valid && !halt_q && !freeze) ? nxt_req : '0;
        end
    end

    assign exc_req = req_q;
    assign halt    = halt_q;

    p_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(exc_req));

    p_halt_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> halt);

    p_quiet_halted_r12: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> (exc_req == '0));

    p_needs_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> (exc_req == '0));
endmodule

// File: rtl/ifetch_exc_detect.sv
// Top of the instruction-side exception detector. It joins the opcode
// checker, the fetch error filter and the request register. It assumes a
// 32-bit word with a 6-bit major opcode and a synchronous active-low reset.
module ifetch_exc_detect
    import ifx_pkg::*;
#(
    parameter int            INSTR_W      = 32,
    parameter int            OPC_W        = 6,
    parameter logic [63:0]   BASE_LEGAL   = 64'h0000_FFFF_FFFF_FFFF,
    parameter logic [63:0]   OPT_MASK     = 64'h00FF_0000_0000_0000,
    parameter logic [63:0]   PRIV_MASK    = 64'h0000_3000_0000_0000,
    parameter bit            ZERO_ILLEGAL = 1'b1,
    parameter bit            ALWAYS_CACHE = 1'b1,
    parameter bit            CE_TRAP      = 1'b0,
    parameter bit            FAULT_TOL    = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [INSTR_W-1:0]   instr_word,
    input  logic [1:0]           fetch_path,
    input  logic                 fetch_err,
    input  logic                 ecc_uncorr,
    input  logic                 ecc_corr,
    input  logic                 cache_enabled,
    input  logic                 cache_inhibit,
    input  logic                 user_mode,
    input  logic [(2**OPC_W)-1:0] opt_enable,
    input  logic                 exc_in_progress,
    input  logic                 exc_enable,
    output logic [EXC_W-1:0]     exc_req,
    output logic                 halt_err
);
    localparam int NUM_OPC = 2**OPC_W;

    logic illegal_w;
    logic priv_w;
    logic bus_w;

    ifx_opcode_chk #(
        .INSTR_W      (INSTR_W),
        .OPC_W        (OPC_W),
        .BASE_LEGAL   (BASE_LEGAL[NUM_OPC-1:0]),
        .OPT_MASK     (OPT_MASK[NUM_OPC-1:0]),
        .PRIV_MASK    (PRIV_MASK[NUM_OPC-1:0]),
        .ZERO_ILLEGAL (ZERO_ILLEGAL)
    ) opc_i (
        .instr    (instr_word),
        .opt_en   (opt_enable),
        .illegal  (illegal_w),
        .priv_hit (priv_w)
    );

    ifx_bus_filter #(
        .ALWAYS_CACHE (ALWAYS_CACHE),
        .CE_TRAP      (CE_TRAP)
    ) bus_i (
        .path      (fetch_path),
        .fetch_err (fetch_err),
        .ecc_ue    (ecc_uncorr),
        .ecc_ce    (ecc_corr),
        .cache_on  (cache_enabled),
        .cache_inh (cache_inhibit),
        .bus_exc   (bus_w)
    );

    ifx_req_reg #(
        .FAULT_TOL (FAULT_TOL)
    ) req_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid     (in_valid),
        .bus_exc   (bus_w),
        .illegal   (illegal_w),
        .priv_hit  (priv_w),
        .user_mode (user_mode),
        .in_prog   (exc_in_progress),
        .exc_en    (exc_enable),
        .exc_req   (exc_req),
        .halt      (halt_err)
    );

    p_periph_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && fetch_path == PATH_PERIPH && fetch_err && !halt_err
         && !(exc_in_progress && !exc_enable)) |=> exc_req[EXC_BUS]);

    p_cache_absorbed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_path == PATH_CACHE && cache_enabled && !cache_inhibit)
        |=> !exc_req[EXC_BUS]);

    p_zero_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ZERO_ILLEGAL && in_valid && instr_word == '0 && !halt_err
         && !(exc_in_progress && !exc_enable))
        |=> (exc_req[EXC_ILL] || exc_req[EXC_BUS]));
endmodule

// File: tb/ifetch_exc_detect_tb_top.sv
`timescale 1ns/1ps
module ifetch_exc_detect_tb_top;
    localparam bit FT = 1'b1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr_word = '0;
    logic [1:0]  fetch_path = '0;
    logic        fetch_err = 1'b0;
    logic        ecc_uncorr = 1'b0;
    logic        ecc_corr = 1'b0;
    logic        cache_enabled = 1'b0;
    logic        cache_inhibit = 1'b0;
    logic        user_mode = 1'b0;
    logic [63:0] opt_enable = '0;
    logic        exc_in_progress = 1'b0;
    logic        exc_enable = 1'b1;
    logic [2:0]  exc_req;
    logic        halt_err;

    int checks = 0;
    int failures = 0;
    logic m_halt = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ifetch_exc_detect dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr_word(instr_word),
        .fetch_path(fetch_path), .fetch_err(fetch_err), .ecc_uncorr(ecc_uncorr),
        .ecc_corr(ecc_corr), .cache_enabled(cache_enabled),
        .cache_inhibit(cache_inhibit), .user_mode(user_mode),
        .opt_enable(opt_enable), .exc_in_progress(exc_in_progress),
        .exc_enable(exc_enable), .exc_req(exc_req), .halt_err(halt_err)
    );

    // Requirement model: fault code for the currently driven inputs
    function automatic logic [2:0] model_code();
        logic [5:0] op;
        logic legal, bus, priv;
        op = instr_word[31:26];
        legal = (op <= 6'h2F) || (op >= 6'h30 && op <= 6'h37 && opt_enable[op]);
        if (instr_word == 32'h0) legal = 1'b0;
        bus = (fetch_path == 2'd0 && fetch_err)
           || (fetch_path == 2'd1 && fetch_err && (!cache_enabled || cache_inhibit))
           || (fetch_path == 2'd2 && ecc_uncorr);
        priv = user_mode && (op == 6'h2C || op == 6'h2D);
        if (bus) return 3'b001;
        if (!legal) return 3'b010;
        if (priv) return 3'b100;
        return 3'b000;
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    task automatic idle_defaults();
        in_valid = 1'b0; instr_word = 32'h0400_0000; fetch_path = 2'd3;
        fetch_err = 1'b0; ecc_uncorr = 1'b0; ecc_corr = 1'b0;
        cache_enabled = 1'b1; cache_inhibit = 1'b0; user_mode = 1'b0;
        opt_enable = '0; exc_in_progress = 1'b0; exc_enable = 1'b1;
    endtask

    // Inputs already driven at a falling edge; results are due after one rising edge
    task automatic step(input string tag);
        logic [2:0] code, exp_req;
        logic frz, nh;
        code = model_code();
        frz = in_valid && FT && !m_halt && exc_in_progress && !exc_enable
              && (code == 3'b001 || code == 3'b010);
        exp_req = (in_valid && !m_halt && !frz) ? code : 3'b000;
        nh = m_halt | frz;
        @(posedge clk);
        @(negedge clk);
        check(tag, "exc_req", exc_req, exp_req);
        check(tag, "halt_err", {2'b00, halt_err}, {2'b00, nh});
        m_halt = nh;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            $display("FAIL R10 watchdog actual=timeout expected=done");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd7319));
        idle_defaults();
        // R1: drive a fault while reset is held
        in_valid = 1'b1; instr_word = 32'hFC00_0000; fetch_path = 2'd0; fetch_err = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", "exc_req in reset", exc_req, 3'b000);
        check("R1", "halt_err in reset", {2'b00, halt_err}, 3'b000);
        idle_defaults();
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R1", "exc_req after reset", exc_req, 3'b000);
        check("R1", "halt_err after reset", {2'b00, halt_err}, 3'b000);

        // R2: only the major opcode matters
        idle_defaults(); in_valid = 1'b1; instr_word = 32'h17FF_FFFF; step("R2");
        instr_word = 32'hE800_0000; step("R2");
        instr_word = 32'hEBFF_FFFF; step("R2");
        instr_word = 32'hBC00_1234; step("R2");
        instr_word = 32'hFC00_0001; step("R2");
        // R3: optional opcodes
        instr_word = 32'hC400_0000; step("R3");
        opt_enable[49] = 1'b1; step("R3");
        instr_word = 32'hDC00_0000; opt_enable = 64'h00FF_0000_0000_0000; step("R3");
        // R4: all-zero word
        idle_defaults(); in_valid = 1'b1; instr_word = 32'h0; step("R4");
        instr_word = 32'h0000_0001; step("R4");
        // R5: peripheral path
        fetch_path = 2'd0; fetch_err = 1'b1; step("R5");
        fetch_err = 1'b0; ecc_uncorr = 1'b1; ecc_corr = 1'b1; step("R5");
        // R6: cache path filtering
        idle_defaults(); in_valid = 1'b1; fetch_path = 2'd1; fetch_err = 1'b1;
        step("R6");
        cache_enabled = 1'b0; step("R6");
        cache_enabled = 1'b1; cache_inhibit = 1'b1; step("R6");
        // R7: local memory ECC
        idle_defaults(); in_valid = 1'b1; fetch_path = 2'd2; ecc_uncorr = 1'b1;
        step("R7");
        ecc_uncorr = 1'b0; ecc_corr = 1'b1; step("R7");
        ecc_corr = 1'b0; fetch_err = 1'b1; step("R7");
        fetch_path = 2'd3; ecc_uncorr = 1'b1; step("R7");
        // R8: privileged opcodes
        idle_defaults(); in_valid = 1'b1; instr_word = 32'hB000_0000; user_mode = 1'b1;
        step("R8");
        user_mode = 1'b0; step("R8");
        user_mode = 1'b1; instr_word = 32'hB7FF_0000; step("R8");
        // R9: priority
        fetch_path = 2'd0; fetch_err = 1'b1; step("R9");
        instr_word = 32'hF800_0000; step("R9");
        fetch_err = 1'b0; step("R9");
        // R10: valid qualification and one-cycle width
        in_valid = 1'b0; fetch_err = 1'b1; step("R10");
        in_valid = 1'b1; step("R10");
        in_valid = 1'b0; step("R10");

        // R9 random mix with exceptions enabled
        for (int i = 0; i < 400; i++) begin
            in_valid = ($urandom % 8) != 0;
            instr_word = ($urandom % 10 == 0) ? 32'h0 : $urandom;
            fetch_path = 2'($urandom % 4);
            fetch_err = ($urandom % 3) == 0;
            ecc_uncorr = ($urandom % 4) == 0;
            ecc_corr = ($urandom % 3) == 0;
            cache_enabled = $urandom % 2;
            cache_inhibit = ($urandom % 4) == 0;
            user_mode = $urandom % 2;
            opt_enable = {$urandom, $urandom};
            exc_in_progress = $urandom % 2;
            exc_enable = 1'b1;
            step("R9 random");
        end

        // R11: fault-tolerant halt
        idle_defaults(); in_valid = 1'b1; exc_in_progress = 1'b1; exc_enable = 1'b0;
        user_mode = 1'b1; instr_word = 32'hB000_0000; step("R11");
        exc_enable = 1'b1; instr_word = 32'hFC00_0000; step("R11");
        exc_enable = 1'b0; step("R11");
        in_valid = 1'b0; exc_in_progress = 1'b0; step("R11");
        // R12: quiet while halted
        in_valid = 1'b1; fetch_path = 2'd0; fetch_err = 1'b1; step("R12");
        instr_word = 32'hB000_0000; fetch_err = 1'b0; step("R12");

        // R1: reset clears the halt
        idle_defaults(); rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        rst_n = 1'b1; m_halt = 1'b0;
        check("R1", "halt_err cleared", {2'b00, halt_err}, 3'b000);
        check("R1", "exc_req cleared", exc_req, 3'b000);

        done = 1'b1;
        finish_run();
    end
endmodule